// File: doc/BRIEF.md
# Port C Change-of-State Interrupt Controller

This block turns level changes on two watched pins of each parallel port group into a host interrupt request. In every group, one pin (called bit 3) fires on a low-to-high change and a second pin (called bit 7) fires on a high-to-low change. Both are taken from the pin level itself. A request can therefore come from an outside signal, or from software driving the same bit when the port is set as an output. Each pin has to return to its idle level before it can fire again.

Every group has its own two-bit mode. The mode can switch the group off, watch bit 3 only, or watch both bits. The requests of all groups are merged into one request. That request is held high for a programmable minimum number of clocks and then steered onto one of six interrupt lines, or onto none. No hardware priority exists between groups or bits. Software finds the source by reading the port C bits of each group.

All interfaces are plain control pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `cos_irq_ctrl`

## Requirements
- R1: A group whose mode code is 2'b00 or 2'b11 (off) never causes a request, whatever its pins do.
- R2: With mode code 2'b01, a 0-to-1 change on the group's bit 3 pin causes one request. Changes on bit 7 are ignored in this mode.
- R3: Once bit 3 has fired, holding it high causes no further request. After it returns low for at least one sampled clock, a new 0-to-1 change fires again.
- R4: With mode code 2'b10, bit 3 behaves as in R2, and a 1-to-0 change on bit 7 also causes one request. Holding bit 7 low causes no further request, and it re-arms only after it returns high.
- R5: A pin change sampled at clock edge n raises the selected line at edge n+2. The path is two synchronizer flops, then the edge detector, then the stretch register.
- R6: Each request holds the merged output high for max(min_width,1) clocks. A new request while the output is high reloads the count, so the output stays high until the count from the latest request runs out.
- R7: The requests of all groups are ORed. Either group alone, or both together, drive the same merged output.
- R8: route_sel codes 1 to 6 drive the merged request onto irq_out bit code-1. Codes 0 and 7 keep all six lines low. At most one line is ever high.
- R9: In reset all lines are low. A pin already at its active level (bit 3 high, bit 7 low) when reset is released causes no request until it has returned to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_bit3 | input | NUM_GROUPS | Bit 3 pin level of each group (fires on rise) |
| pin_bit7 | input | NUM_GROUPS | Bit 7 pin level of each group (fires on fall) |
| grp_mode | input | 2*NUM_GROUPS | Two-bit mode per group, group g at bits [2g+1:2g] |
| route_sel | input | 3 | Output line select, 0 and 7 mean none |
| min_width | input | CNT_W | Minimum request width in clocks (0 acts as 1) |
| irq_out | output | 6 | Interrupt lines |

## Verification
The bench sweeps every group, mode code, trigger bit and route code, and varies the width. For each case it computes the expected first cycle, length and line of the request. A design that fires on the wrong polarity, or that ignores the mode, would show up as a request where none is due or a missing one. A leaky route decoder would show up as a wrong line value. Holding a pin at its active level after firing checks the re-arm rule: a level-sensitive detector would repeat its request there. A single-cycle return to idle then checks that the pin does re-arm. Back-to-back requests from two groups check that the stretch counter reloads and does not cut the output short. Pins held active through reset check that leaving reset does not produce a false edge.

// File: rtl/cos_irq_pkg.sv
package cos_irq_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_RISE3   = 2'b01,
    MODE_BOTH    = 2'b10,
    MODE_OFF_ALT = 2'b11
  } grp_mode_e;

  localparam int NUM_LINES = 6;
  localparam int ROUTE_W   = $clog2(NUM_LINES + 1);
endpackage

// File: rtl/cos_irq_sync.sv
module cos_irq_sync #(
  parameter int             W       = 2,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST_VAL;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cos_irq_detect.sv
module cos_irq_detect
  import cos_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       lvl3,
  input  logic       lvl7,
  output logic       pulse
);
  // Previous levels reset to the active level, so a pin held active
  // across reset shows no edge until it has been idle once.
  logic prev3, prev7;
  logic rise3, fall7;
  logic en3, en7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev3 <= 1'b1;
      prev7 <= 1'b0;
    end else begin
      prev3 <= lvl3;
      prev7 <= lvl7;
    end
  end

  assign rise3 = lvl3 & ~prev3;
  assign fall7 = ~lvl7 & prev7;

  always_comb begin
    en3 = 1'b0;
    en7 = 1'b0;
    case (grp_mode_e'(mode))
      MODE_RISE3: en3 = 1'b1;
      MODE_BOTH: begin
        en3 = 1'b1;
        en7 = 1'b1;
      end
      default: ;
    endcase
  end

  assign pulse = (en3 & rise3) | (en7 & fall7);
endmodule

// File: rtl/cos_irq_stretch.sv
module cos_irq_stretch #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse,
  input  logic [CNT_W-1:0] min_width,
  output logic             req
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  assign load_val = (min_width == '0) ? ONE : min_width;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (pulse) cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - ONE;
  end

  assign req = (cnt != '0);
endmodule

// File: rtl/cos_irq_route.sv
module cos_irq_route
  import cos_irq_pkg::*;
(
  input  logic               req,
  input  logic [ROUTE_W-1:0] route_sel,
  output logic [NUM_LINES-1:0] irq_out
);
  genvar i;
  generate
    for (i = 0; i < NUM_LINES; i++) begin : g_line
      assign irq_out[i] = req && (route_sel == ROUTE_W'(i + 1));
    end
  endgenerate
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_irq_pkg::*;
#(
  parameter int NUM_GROUPS  = 2,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_GROUPS-1:0]   pin_bit3,
  input  logic [NUM_GROUPS-1:0]   pin_bit7,
  input  logic [2*NUM_GROUPS-1:0] grp_mode,
  input  logic [ROUTE_W-1:0]      route_sel,
  input  logic [CNT_W-1:0]        min_width,
  output logic [NUM_LINES-1:0]    irq_out
);
  logic [NUM_GROUPS-1:0] grp_pulse;
  logic                  req_stretched;

  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
      logic [1:0] lvl;  // {bit7, bit3}

      cos_irq_sync #(
        .W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)
      ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({pin_bit7[g], pin_bit3[g]}),
        .q(lvl)
      );

      cos_irq_detect u_det (
        .clk(clk), .rst_n(rst_n),
        .mode(grp_mode[2*g +: 2]),
        .lvl3(lvl[0]), .lvl7(lvl[1]),
        .pulse(grp_pulse[g])
      );
    end
  endgenerate

  cos_irq_stretch #(.CNT_W(CNT_W)) u_stretch (
    .clk(clk), .rst_n(rst_n),
    .pulse(|grp_pulse),
    .min_width(min_width),
    .req(req_stretched)
  );

  cos_irq_route u_route (
    .req(req_stretched),
    .route_sel(route_sel),
    .irq_out(irq_out)
  );
endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk
  import cos_irq_pkg::*;
#(
  parameter int NUM_GROUPS = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [2*NUM_GROUPS-1:0] grp_mode,
  input logic [ROUTE_W-1:0]      route_sel,
  input logic [NUM_GROUPS-1:0]   grp_pulse,
  input logic                    req,
  input logic [NUM_LINES-1:0]    irq_out
);
  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_off
      assert_off_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_mode[2*g +: 2] == 2'b00 || grp_mode[2*g +: 2] == 2'b11) |-> !grp_pulse[g]);
    end
  endgenerate

  assert_pulse_raises_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp_pulse) |=> req);

  assert_req_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req) |-> $past(|grp_pulse));

  assert_one_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_out));

  assert_no_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (route_sel == 0 || route_sel == 7) |-> (irq_out == '0));

  assert_line_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (route_sel >= 1 && route_sel <= 6) |-> (irq_out[route_sel - 1] == req));
endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .grp_mode(grp_mode), .route_sel(route_sel),
  .grp_pulse(grp_pulse), .req(req_stretched), .irq_out(irq_out)
);

// File: tb/cos_irq_ctrl_tb.sv
`timescale 1ns/1ps
module cos_irq_ctrl_tb;
  localparam int G = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [G-1:0] pin_bit3 = '0;
  logic [G-1:0] pin_bit7 = '1;
  logic [2*G-1:0] grp_mode = '0;
  logic [2:0]   route_sel = '0;
  logic [3:0]   min_width = '0;
  logic [5:0]   irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cos_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pin_bit3(pin_bit3), .pin_bit7(pin_bit7),
    .grp_mode(grp_mode), .route_sel(route_sel), .min_width(min_width),
    .irq_out(irq_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(input int n, output int first, output int len, output int orv);
    first = -1; len = 0; orv = 0;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      if (irq_out != 0) begin
        if (first < 0) first = j;
        len++;
        orv = orv | int'(irq_out);
      end
    end
  endtask

  task automatic go_idle();
    pin_bit3 = '0;
    pin_bit7 = '1;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    int f, l, o;
    // R9: pins held active through reset
    pin_bit3 = '1; pin_bit7 = '0;
    grp_mode = 4'b1010; route_sel = 3'd1; min_width = 4'd2;
    repeat (5) @(negedge clk);
    chk("R9 reset lines low", int'(irq_out), 0);
    rst_n = 1'b1;
    measure(10, f, l, o);
    chk("R9 no request after reset with active pins", l, 0);
    go_idle();
    pin_bit7[0] = 1'b0;
    measure(10, f, l, o);
    chk("R4 bit7 fall after reset", l, 2);
    go_idle();

    // Sweep: group, mode, source bit, route
    for (int g = 0; g < G; g++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 2; s++)
          for (int r = 0; r < 8; r++) begin
            int idx, w, ew, fires, elen, efirst, eor;
            string tag;
            idx = ((g * 4 + m) * 2 + s) * 8 + r;
            w = idx % 6;
            grp_mode = '0;
            grp_mode[2*g +: 2] = 2'(m);
            route_sel = 3'(r);
            min_width = 4'(w);
            go_idle();
            if (s == 0) pin_bit3[g] = 1'b1; else pin_bit7[g] = 1'b0;
            fires = ((s == 0) && (m == 1 || m == 2)) || ((s == 1) && (m == 2)) ? 1 : 0;
            ew = (w == 0) ? 1 : w;
            elen = (fires == 1 && r >= 1 && r <= 6) ? ew : 0;
            efirst = (elen > 0) ? 2 : -1;
            eor = (elen > 0) ? (1 << (r - 1)) : 0;
            tag = (m == 0 || m == 3) ? "R1" : ((s == 0) ? "R2" : "R4");
            measure(12, f, l, o);
            chk({tag, " R6 width"}, l, elen);
            chk("R5 latency", f, efirst);
            chk("R8 line", o, eor);
            measure(10, f, l, o);
            chk((s == 0) ? "R3 held high" : "R4 held low", l, 0);
          end

    // R3: one-cycle return to idle re-arms bit 3
    grp_mode = 4'b0001; route_sel = 3'd1; min_width = 4'd1;
    go_idle();
    pin_bit3[0] = 1'b1;
    measure(8, f, l, o);
    chk("R3 first fire", l, 1);
    pin_bit3[0] = 1'b0;
    @(negedge clk);
    pin_bit3[0] = 1'b1;
    measure(10, f, l, o);
    chk("R3 re-arm after one idle cycle", l, 1);

    // R6/R7: retrigger from the other group reloads the count
    grp_mode = 4'b0101; route_sel = 3'd6; min_width = 4'd4;
    go_idle();
    pin_bit3[0] = 1'b1;
    @(negedge clk);
    chk("R5 low right after edge", int'(irq_out), 0);
    pin_bit3[1] = 1'b1;
    measure(12, f, l, o);
    chk("R6 reload length", l, 5);
    chk("R7 start", f, 1);
    chk("R7 line 6", o, 32);

    // R7: both groups in the same cycle give one request
    go_idle();
    pin_bit3 = '1;
    measure(12, f, l, o);
    chk("R7 simultaneous length", l, 4);
    chk("R7 simultaneous start", f, 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule